// File: doc/BRIEF.md
# Four-Lane Loopback Self-Test Engine

The engine exercises a four-lane serial datapath without outside equipment. It generates a symbol stream on a transmit side and loops that stream back onto four receive lanes. Each lane compares what it receives against what was sent. Software controls it through a small 16-bit register window. The usual sequence is three writes: configure the pattern and symbol width, set enable, then set start. After letting the test run for a while, software sets stop. It then polls until the start bit drops and reads the counters. A lane is considered healthy when it has seen at least one frame and no mismatched symbol.

The engine is a five-state machine. ST_OFF is disabled. ST_READY is enabled and idle, which is also the state after a finished run. ST_RUN generates symbols. ST_DRAIN means a stop was requested and the current frame is being finished. ST_FLUSH is one cycle in which the last looped-back symbol reaches the lanes.

The transitions are:
- **enable**: ST_OFF to ST_READY, on a control write with the enable bit set.
- **start**: ST_READY to ST_RUN, on a control write with enable and start both set.
- **stop**: ST_RUN to ST_DRAIN, on a control write with enable and stop both set.
- **frame_end**: ST_DRAIN to ST_FLUSH, when the last symbol of a frame is generated.
- **settle**: ST_FLUSH to ST_READY, unconditionally.
- **abort**: from any state to ST_OFF, on a control write with the enable bit clear.

Generated symbols are replaced by simple stand-ins: a fixed four-word cycle, two alternating-word patterns, and a PRBS7 sequence. An error-injection input flips bit 0 of one lane's looped-back symbol, so that fault detection can be exercised.

Top module: `bist_engine`

## Requirements
- R1: After reset, every mapped register reads 0, `tx_vld` is 0 and `pass` is 0.
- R2: The control register (address 0) has these fields: bits [11:10] pattern type, bit 12 symbol width (1 = 10-bit, 0 = 8-bit), bit 13 enable, bit 14 stop, bit 15 start; bits [9:0] read 0. The type and width fields are captured by a control write only while start reads 0; while a test is active they are ignored.
- R3: Each generated symbol follows the pattern type. Type 0 cycles 0x17C, 0x283, 0x0F0, 0x30F. Type 1 alternates 0x2AA, 0x155. Type 2 alternates 0x3E0, 0x01F. Type 3 is {s[2:0], s}, where s is a 7-bit register seeded to 0x7F that shifts left each symbol, taking s[6]^s[5] into bit 0. In 8-bit mode, bits [9:8] of the symbol are 0. Every pattern restarts at its first symbol on start.
- R4: Start takes effect only from ST_READY, which requires enable to have been set by an earlier write. A start from ST_OFF only enables the engine. Writing enable = 0 moves to ST_OFF at once, clearing start and stop, and generation stops in the next cycle.
- R5: Writing 1 to the stop bit while running sets it; start stays 1. Generation continues to the end of the current frame, then for one flush cycle. After that both bits clear together and enable stays 1. A stop written while not running is ignored.
- R6: Address 1 counts generated frames of FRAME_LEN symbols. It saturates at its maximum instead of wrapping.
- R7: Addresses 2 to 5 count frames received on lanes 0 to 3, and they saturate. After a stop completes, each equals the transmit count.
- R8: Addresses 6 to 9 count mismatched symbols on lanes 0 to 3, and they saturate. A bit of `err_inject` held high for a cycle while generating corrupts exactly one symbol on its lane.
- R9: All counters clear in the cycle the start write is accepted.
- R10: `pass` is 1 exactly when every lane's error count is 0 and every lane's frame count is nonzero.
- R11: Addresses 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for `reg_addr` |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| err_inject | input | LANES | Per-lane corruption of the symbol generated this cycle |
| tx_sym | output | 10 | Symbol currently generated |
| tx_vld | output | 1 | A symbol is generated this cycle |
| pass | output | 1 | All lanes error-free with frames seen |

## Verification
The bench builds the engine with CNT_W = 6 and FRAME_LEN = 4. With these values a counter saturates at 63 after about 250 cycles, so transmit, receive and error saturation are all reached in one long run. The short frame also makes the drain length after a stop vary between one and four symbols, depending on when the stop lands. A behavioural model predicts the transmitted symbol, `pass` and the addressed register every cycle. Directed sequences add an ignored start and an ignored reconfiguration, a mid-run abort, timed injection, and a restart that must clear saturated counters.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_READY,
        ST_RUN,
        ST_DRAIN,
        ST_FLUSH
    } bist_state_e;

    typedef enum logic [1:0] {
        PAT_DET,
        PAT_RND,
        PAT_JIT,
        PAT_PRBS
    } bist_pat_e;

    localparam int SYM_W       = 10;
    localparam int REG_W       = 16;
    localparam int CTL_TYPE_LO = 10;
    localparam int CTL_WIDE    = 12;
    localparam int CTL_EN      = 13;
    localparam int CTL_STOP    = 14;
    localparam int CTL_STRT    = 15;
    localparam int ADR_CTRL    = 0;
    localparam int ADR_TXF     = 1;
    localparam int ADR_RXF     = 2;
endpackage

// File: rtl/bist_patgen.sv
module bist_patgen
    import bist_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  bist_pat_e        sel,
    input  logic             wide,
    output logic [SYM_W-1:0] sym
);
    localparam logic [SYM_W-1:0] NARROW_MASK = SYM_W'(8'hFF);

    logic [1:0]       phase_q;
    logic [6:0]       lfsr_q;
    logic [SYM_W-1:0] raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            lfsr_q  <= 7'h7F;
        end else if (restart) begin
            phase_q <= '0;
            lfsr_q  <= 7'h7F;
        end else if (step) begin
            phase_q <= phase_q + 2'd1;
            lfsr_q  <= {lfsr_q[5:0], lfsr_q[6] ^ lfsr_q[5]};
        end
    end

    always_comb begin
        unique case (sel)
            PAT_DET: begin
                unique case (phase_q)
                    2'd0:    raw = 10'h17C;
                    2'd1:    raw = 10'h283;
                    2'd2:    raw = 10'h0F0;
                    default: raw = 10'h30F;
                endcase
            end
            PAT_RND:  raw = phase_q[0] ? 10'h155 : 10'h2AA;
            PAT_JIT:  raw = phase_q[0] ? 10'h01F : 10'h3E0;
            default:  raw = {lfsr_q[2:0], lfsr_q};
        endcase
        sym = wide ? raw : (raw & NARROW_MASK);
    end
endmodule

// File: rtl/bist_lane_chk.sv
module bist_lane_chk
    import bist_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic             last,
    input  logic [SYM_W-1:0] ref_sym,
    input  logic [SYM_W-1:0] rx_sym,
    output logic [CNT_W-1:0] frames,
    output logic [CNT_W-1:0] errs
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frames <= '0;
            errs   <= '0;
        end else if (clr) begin
            frames <= '0;
            errs   <= '0;
        end else if (vld) begin
            if (last && frames != CNT_MAX) frames <= frames + 1'b1;
            if (rx_sym != ref_sym && errs != CNT_MAX) errs <= errs + 1'b1;
        end
    end
endmodule

// File: rtl/bist_engine.sv
module bist_engine
    import bist_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int CNT_W     = 16,
    parameter int FRAME_LEN = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [LANES-1:0]  err_inject,
    output logic [9:0]        tx_sym,
    output logic              tx_vld,
    output logic              pass
);
    localparam int FL_W     = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int ERR_BASE = ADR_RXF + LANES;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    bist_state_e state_q, state_d;
    bist_pat_e   cfg_type_q;
    logic        cfg_wide_q;
    logic        ctrl_wr, abort, start_pulse, busy, gen_on, gen_last;
    logic [FL_W-1:0]  sym_q;
    logic [CNT_W-1:0] txf_q;
    logic [SYM_W-1:0] gen_sym, lb_sym;
    logic             lb_vld, lb_last;
    logic [LANES-1:0] lb_inj;
    logic [CNT_W-1:0] rxf_q [LANES];
    logic [CNT_W-1:0] err_q [LANES];
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[CTL_TYPE_LO-1:0];
    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
    assign abort    = ctrl_wr && !reg_wdata[CTL_EN];
    assign busy     = (state_q == ST_RUN) || (state_q == ST_DRAIN) || (state_q == ST_FLUSH);
    assign gen_on   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    assign gen_last = gen_on && (sym_q == FL_W'(FRAME_LEN - 1));

    // next-state logic
    always_comb begin
        state_d     = state_q;
        start_pulse = 1'b0;
        if (abort) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   if (ctrl_wr) state_d = ST_READY;
                ST_READY: if (ctrl_wr && reg_wdata[CTL_STRT]) begin
                    state_d     = ST_RUN;
                    start_pulse = 1'b1;
                end
                ST_RUN:   if (ctrl_wr && reg_wdata[CTL_STOP]) state_d = ST_DRAIN;
                ST_DRAIN: if (gen_last) state_d = ST_FLUSH;
                ST_FLUSH: state_d = ST_READY;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            cfg_type_q <= PAT_DET;
            cfg_wide_q <= 1'b0;
            sym_q      <= '0;
            txf_q      <= '0;
            lb_vld     <= 1'b0;
            lb_last    <= 1'b0;
            lb_sym     <= '0;
            lb_inj     <= '0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr && !busy) begin
                cfg_type_q <= bist_pat_e'(reg_wdata[CTL_TYPE_LO +: 2]);
                cfg_wide_q <= reg_wdata[CTL_WIDE];
            end
            if (start_pulse) begin
                sym_q <= '0;
                txf_q <= '0;
            end else if (gen_on) begin
                sym_q <= gen_last ? '0 : sym_q + 1'b1;
                if (gen_last && txf_q != CNT_MAX) txf_q <= txf_q + 1'b1;
            end
            lb_vld  <= gen_on;
            lb_last <= gen_last;
            lb_sym  <= gen_sym;
            lb_inj  <= err_inject;
        end
    end

    bist_patgen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_pulse),
        .step    (gen_on),
        .sel     (cfg_type_q),
        .wide    (cfg_wide_q),
        .sym     (gen_sym)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYM_W-1:0] rx_sym;
        assign rx_sym = lb_sym ^ SYM_W'(lb_inj[g]);
        bist_lane_chk #(.CNT_W(CNT_W)) u_chk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (start_pulse),
            .vld     (lb_vld),
            .last    (lb_last),
            .ref_sym (lb_sym),
            .rx_sym  (rx_sym),
            .frames  (rxf_q[g]),
            .errs    (err_q[g])
        );
    end

    // outputs
    always_comb begin
        reg_rdata = '0;
        pass      = 1'b1;
        if (reg_addr == ADDR_W'(ADR_CTRL)) begin
            reg_rdata[CTL_STRT]          = busy;
            reg_rdata[CTL_STOP]          = (state_q == ST_DRAIN) || (state_q == ST_FLUSH);
            reg_rdata[CTL_EN]            = (state_q != ST_OFF);
            reg_rdata[CTL_WIDE]          = cfg_wide_q;
            reg_rdata[CTL_TYPE_LO +: 2]  = cfg_type_q;
        end else if (reg_addr == ADDR_W'(ADR_TXF)) begin
            reg_rdata[CNT_W-1:0] = txf_q;
        end
        for (int i = 0; i < LANES; i++) begin
            if (reg_addr == ADDR_W'(ADR_RXF + i))  reg_rdata[CNT_W-1:0] = rxf_q[i];
            if (reg_addr == ADDR_W'(ERR_BASE + i)) reg_rdata[CNT_W-1:0] = err_q[i];
            if (err_q[i] != '0 || rxf_q[i] == '0) pass = 1'b0;
        end
        tx_sym = gen_sym;
        tx_vld = gen_on;
    end
endmodule

// File: rtl/bist_engine_chk.sv
module bist_engine_chk
    import bist_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input bist_state_e      state,
    input logic [CNT_W-1:0] txf,
    input logic [CNT_W-1:0] rxf0,
    input logic             clr,
    input logic             abort
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R5
    stop_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && !abort) |=> (state == ST_READY));

    // R4
    off_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (state == ST_OFF || state == ST_READY));

    // R6
    tx_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txf == CNT_MAX && !clr) |=> (txf == CNT_MAX));

    // R7
    frames_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && !abort) |=> (rxf0 == txf));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (txf == '0 && rxf0 == '0));
endmodule

bind bist_engine bist_engine_chk #(.CNT_W(CNT_W)) u_assert (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state_q),
    .txf   (txf_q),
    .rxf0  (rxf_q[0]),
    .clr   (start_pulse),
    .abort (abort)
);

// File: tb/bist_engine_tb_top.sv
`timescale 1ns/1ps
module bist_engine_tb_top;
    localparam int LANES = 4;
    localparam int CNT_W = 6;
    localparam int FL    = 4;
    localparam int CMAX  = 63;
    localparam logic [15:0] EN = 16'h2000, STOP = 16'h4000, STRT = 16'h8000, WIDE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  err_inject = '0;
    logic [9:0]  tx_sym;
    logic        tx_vld, pass;

    always #10 clk = ~clk;

    bist_engine #(.LANES(LANES), .CNT_W(CNT_W), .FRAME_LEN(FL), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_inject(err_inject),
        .tx_sym(tx_sym), .tx_vld(tx_vld), .pass(pass));

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;

    // behavioural reference model
    int ms, mtype, mw10, mphase, mlfsr, msym, mtxf;
    int mrxf [4];
    int merr [4];
    bit minj [4];
    bit mlbv, mlblast;

    function automatic logic [9:0] exp_sym();
        logic [9:0] s;
        case (mtype)
            0: s = (mphase == 0) ? 10'h17C : (mphase == 1) ? 10'h283 : (mphase == 2) ? 10'h0F0 : 10'h30F;
            1: s = (mphase % 2) ? 10'h155 : 10'h2AA;
            2: s = (mphase % 2) ? 10'h01F : 10'h3E0;
            default: s = {mlfsr[2:0], mlfsr[6:0]};
        endcase
        if (mw10 == 0) s[9:8] = 2'b00;
        return s;
    endfunction

    function automatic logic [15:0] exp_rd(int a);
        if (a == 0) return 16'((ms >= 2) << 15 | (ms >= 3) << 14 | (ms != 0) << 13 | mw10 << 12 | mtype << 10);
        if (a == 1) return 16'(mtxf);
        if (a >= 2 && a < 6) return 16'(mrxf[a-2]);
        if (a >= 6 && a < 10) return 16'(merr[a-6]);
        return 16'h0;
    endfunction

    function automatic string rd_req(int a);
        if (a == 0) return "R2 R4 R5";
        if (a == 1) return "R6";
        if (a < 6) return "R7";
        if (a < 10) return "R8";
        return "R11";
    endfunction

    function automatic bit exp_pass();
        for (int l = 0; l < 4; l++) if (merr[l] != 0 || mrxf[l] == 0) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        bit gon, glast, cw, busy, st;
        if (!rst_n) begin
            ms = 0; mtype = 0; mw10 = 0; mphase = 0; mlfsr = 127; msym = 0; mtxf = 0;
            mlbv = 0; mlblast = 0;
            for (int l = 0; l < 4; l++) begin mrxf[l] = 0; merr[l] = 0; minj[l] = 0; end
        end else begin
            gon   = (ms == 2 || ms == 3);
            glast = gon && msym == FL - 1;
            cw    = reg_wr && reg_addr == 0;
            busy  = ms >= 2;
            st    = 0;
            if (mlbv) for (int l = 0; l < 4; l++) begin
                if (mlblast && mrxf[l] < CMAX) mrxf[l]++;
                if (minj[l] && merr[l] < CMAX) merr[l]++;
            end
            mlbv = gon; mlblast = glast;
            for (int l = 0; l < 4; l++) minj[l] = err_inject[l];
            if (gon) begin
                if (glast && mtxf < CMAX) mtxf++;
                mphase = (mphase + 1) % 4;
                mlfsr  = ((mlfsr << 1) & 127) | (((mlfsr >> 6) ^ (mlfsr >> 5)) & 1);
                msym   = glast ? 0 : msym + 1;
            end
            if (cw && !busy) begin mtype = int'(reg_wdata[11:10]); mw10 = int'(reg_wdata[12]); end
            if (cw && !reg_wdata[13]) ms = 0;
            else case (ms)
                0: if (cw) ms = 1;
                1: if (cw && reg_wdata[15]) begin ms = 2; st = 1; end
                2: if (cw && reg_wdata[14]) ms = 3;
                3: if (glast) ms = 4;
                default: ms = 1;
            endcase
            if (st) begin
                mtxf = 0; mphase = 0; mlfsr = 127; msym = 0;
                for (int l = 0; l < 4; l++) begin mrxf[l] = 0; merr[l] = 0; end
            end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (cmp_on) begin
        check("R3 tx_sym", 16'(tx_sym), 16'(exp_sym()));
        check("R4 R5 tx_vld", 16'(tx_vld), 16'(ms == 2 || ms == 3));
        check(rd_req(int'(reg_addr)), reg_rdata, exp_rd(int'(reg_addr)));
        check("R10 pass", 16'(pass), 16'(exp_pass()));
    end

    task automatic wr(logic [15:0] d);
        @(posedge clk); #5;
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = d;
        @(posedge clk); #5;
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] v);
        reg_addr = 4'(a);
        @(negedge clk);
        v = reg_rdata;
        @(posedge clk); #5;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic stop_and_wait(logic [15:0] cfg);
        logic [15:0] v;
        wr(cfg | EN | STOP);
        rd(0, v);
        check("R5 stop bit set, start held", v & 16'hE000, 16'hE000);
        for (int k = 0; k < 12 && v[15]; k++) rd(0, v);
        check("R5 start and stop cleared", v & 16'hE000, 16'h2000);
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 10; a++) begin rd(a, v); check("R1 reset register", v, 16'h0); end
        check("R1 reset tx_vld", 16'(tx_vld), 16'h0);
        check("R1 reset pass", 16'(pass), 16'h0);
        rd(12, v); check("R11 unmapped", v, 16'h0);
        cmp_on = 1;

        // R4 start ignored from disabled state
        wr(EN | STRT | WIDE);
        rd(0, v); check("R4 start from off only enables", v, EN | WIDE);
        check("R4 no generation", 16'(tx_vld), 16'h0);

        // R3 deterministic 10-bit run, clean
        wr(EN | WIDE);
        wr(EN | WIDE | STRT);
        check("R3 first deterministic symbol", 16'(tx_sym), 16'h017C);
        idle(2);
        // R2 reconfiguration while running is ignored
        wr(EN | 16'h0C00);
        rd(0, v); check("R2 config held while active", v, EN | STRT | WIDE);
        idle(20);
        rd(5, v);
        stop_and_wait(WIDE);
        rd(1, v); rd(2, v);
        check("R7 rx equals tx lane0", exp_rd(2), exp_rd(1));
        check("R10 clean run passes", 16'(pass), 16'h1);

        // R8 PRBS 8-bit run with injection on lane 2 for 3 cycles
        wr(EN | 16'h0C00);
        wr(EN | 16'h0C00 | STRT);
        check("R9 counters cleared at start", 16'(exp_rd(1)), 16'h0);
        idle(4);
        err_inject = 4'b0100;
        idle(3);
        err_inject = 4'b0000;
        idle(7);
        stop_and_wait(16'h0C00);
        rd(8, v); check("R8 lane2 error count", v, 16'd3);
        rd(7, v); check("R8 lane1 untouched", v, 16'd0);
        check("R10 fail with errors", 16'(pass), 16'h0);

        // R3 alternating patterns
        wr(EN | WIDE | 16'h0400);
        wr(EN | WIDE | 16'h0400 | STRT);
        idle(9);
        stop_and_wait(WIDE | 16'h0400);
        wr(EN | 16'h0800);
        wr(EN | 16'h0800 | STRT);
        idle(6);
        // R4 abort mid-run
        wr(16'h0000);
        rd(0, v); check("R4 abort clears start", v, 16'h0800);
        check("R4 abort stops generation", 16'(tx_vld), 16'h0);

        // R6 saturation with continuous errors on lane 1
        wr(EN | WIDE);
        wr(EN | WIDE | STRT);
        err_inject = 4'b0010;
        idle(300);
        err_inject = 4'b0000;
        rd(1, v); check("R6 tx saturated", v, 16'(CMAX));
        stop_and_wait(WIDE);
        rd(1, v); check("R6 tx holds saturated", v, 16'(CMAX));
        rd(3, v); check("R7 rx saturated", v, 16'(CMAX));
        rd(7, v); check("R8 err saturated", v, 16'(CMAX));
        // R5 stop ignored when idle
        wr(EN | WIDE | STOP);
        rd(0, v); check("R5 stop ignored when ready", v, EN | WIDE);
        // R9 restart clears saturated counters
        wr(EN | WIDE | STRT);
        rd(1, v); check("R9 tx cleared on restart", v, 16'h0);
        idle(5);
        stop_and_wait(WIDE);
        rd(14, v); check("R11 unmapped high address", v, 16'h0);
        idle(2);
        finish_sim();
    end
endmodule